// File: doc/BRIEF.md
# Dual-Input Reference Clock Selector

This controller decides which of two candidate reference clocks feeds a downstream PLL. It does not touch the clocks themselves. It receives one synchronous alarm level per input from an external monitor and returns a registered select bit for the clock multiplexer.

Manual operation takes the select from an external pin or from a register bit. Automatic operation uses a two-entry priority setting and the alarm levels. It fails over to the healthy input, and it can optionally return to the preferred input once that input has been clean for a programmable number of cycles. When both inputs are alarmed, the controller raises a hold request for the PLL. The active-input indicator keeps the input that was last in use. A one-cycle pulse marks every change of selection and every exit from hold.

The active input is always visible on a status bit. A separate indicator output is driven only when its output enable is set, and it floats otherwise.

Top module: `ref_clk_selector`

## Requirements
- R1: After reset, input 1 is selected (`active_sel_o`=0), `hold_o` is 0 and `switch_o` is 0.
- R2: With `auto_en_i`=0, the selection one clock later equals `sel_pin_i` when `sel_pin_en_i`=1, and equals `sel_reg_i` otherwise. Select value 0 means input 1 and value 1 means input 2. `hold_o` stays 0 in manual mode.
- R3: Each priority field is decoded as 2'b00 = input 1 and 2'b01 = input 2. If either field holds 2'b10 or 2'b11, or if both fields name the same input, input 1 is first priority and input 2 is second. Otherwise `prio_first_i` names the first-priority input.
- R4: In automatic mode, outside hold, if the selected input is alarmed and the other input is clean, selection moves to the other input on the next clock.
- R5: In automatic mode, outside hold, if both inputs are alarmed, `hold_o` rises on the next clock and `active_sel_o` keeps its value for as long as hold lasts.
- R6: In hold, once at least one input is clean, the next clock clears `hold_o`. On that same clock the block selects the first-priority input if it is clean and the second-priority input otherwise, and it pulses `switch_o`.
- R7: With `revert_en_i`=1, if a clean non-first-priority input is in use, selection returns to the first-priority input on the (T+1)-th consecutive clock edge at which the first-priority input is clean. Here T is `valid_time_i`.
- R8: With `revert_en_i`=0, a clean selected input stays selected regardless of priority.
- R9: `switch_o` is high for exactly the cycles that follow an edge where the selection changed or hold was left, and is low otherwise.
- R10: `active_sel_o` always shows the selection. `act_ind_o` equals it when `act_oe_i`=1 and is high impedance when `act_oe_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | 1 = automatic selection, 0 = manual |
| revert_en_i | input | 1 | 1 = revertive automatic policy |
| prio_first_i | input | 2 | First-priority input code |
| prio_second_i | input | 2 | Second-priority input code |
| sel_pin_en_i | input | 1 | Manual select taken from pin when 1 |
| sel_pin_i | input | 1 | Manual select pin |
| sel_reg_i | input | 1 | Manual select register bit |
| alarm_i | input | 2 | Alarm levels, bit 0 = input 1, bit 1 = input 2 |
| valid_time_i | input | TIMER_W | Revert validation time T in cycles |
| act_oe_i | input | 1 | Enables the indicator output |
| active_sel_o | output | 1 | Selected input (0 = input 1, 1 = input 2), readable status |
| act_ind_o | output | 1 | Tri-state active-input indicator |
| hold_o | output | 1 | Hold request to the PLL |
| switch_o | output | 1 | One-cycle pulse on selection change or hold exit |

## Verification
The assertions check several rules on every cycle. Manual selection follows the chosen source one clock later, and hold never appears in manual mode. Failover to a clean input happens on the next edge, a double alarm leads to hold, and the selection is frozen while hold lasts. The switch pulse matches selection changes, and the indicator matches the status bit when enabled. Other behaviour can only be shown by the bench's scenarios against its reference model: the exact revert delay measured in clean cycles, the priority fallback for reserved or duplicate codes, which input is picked on hold exit, the absence of reverting under the non-revertive policy, and the high-impedance indicator.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } rcs_state_e;

  localparam logic [1:0] PRIO_IN1 = 2'b00;
  localparam logic [1:0] PRIO_IN2 = 2'b01;
  localparam int unsigned NUM_IN  = 2;
endpackage

// File: rtl/rcs_prio_decode.sv
module rcs_prio_decode
  import rcs_pkg::*;
(
  input  logic [1:0] prio_first_i,
  input  logic [1:0] prio_second_i,
  output logic       first_o,
  output logic       second_o
);
  logic [NUM_IN-1:0] code_ok;
  logic [1:0]        codes [NUM_IN];

  assign codes[0] = prio_first_i;
  assign codes[1] = prio_second_i;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
    assign code_ok[g] = (codes[g] == PRIO_IN1) || (codes[g] == PRIO_IN2);
  end

  logic distinct;
  assign distinct = (prio_first_i != prio_second_i);

  always_comb begin
    if (&code_ok && distinct) first_o = prio_first_i[0];
    else                      first_o = 1'b0;
    second_o = ~first_o;
  end
endmodule

// File: rtl/rcs_valid_timer.sv
module rcs_valid_timer #(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [TIMER_W-1:0] limit_i,
  output logic               done_o
);
  localparam logic [TIMER_W-1:0] CNT_MAX = {TIMER_W{1'b1}};

  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // counts clean edges already seen; the current clean edge completes T+1
  assign done_o = !clear_i && (cnt_q >= limit_i);
endmodule

// File: rtl/rcs_sel_fsm.sv
module rcs_sel_fsm
  import rcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_en_i,
  input  logic              revert_en_i,
  input  logic              man_sel_i,
  input  logic              first_i,
  input  logic              second_i,
  input  logic [NUM_IN-1:0] alarm_i,
  input  logic              revert_ok_i,
  output logic              sel_o,
  output logic              hold_o,
  output logic              switch_o
);
  rcs_state_e state_q, state_d;
  logic       sel_q, sel_d;
  logic       sw_q, sw_d;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    sw_d    = 1'b0;
    if (!auto_en_i) begin
      state_d = ST_RUN;
      sel_d   = man_sel_i;
      sw_d    = (man_sel_i != sel_q);
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (alarm_i[sel_q]) begin
            if (!alarm_i[~sel_q]) begin
              sel_d = ~sel_q;
              sw_d  = 1'b1;
            end else begin
              state_d = ST_HOLD;
            end
          end else if (revert_en_i && (sel_q != first_i) && revert_ok_i) begin
            sel_d = first_i;
            sw_d  = 1'b1;
          end
        end
        ST_HOLD: begin
          if (alarm_i != '1) begin
            state_d = ST_RUN;
            sel_d   = alarm_i[first_i] ? second_i : first_i;
            sw_d    = 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      sel_q   <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      sw_q    <= sw_d;
    end
  end

  assign sel_o    = sel_q;
  assign hold_o   = (state_q == ST_HOLD);
  assign switch_o = sw_q;
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
  import rcs_pkg::*;
#(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_en_i,
  input  logic               revert_en_i,
  input  logic [1:0]         prio_first_i,
  input  logic [1:0]         prio_second_i,
  input  logic               sel_pin_en_i,
  input  logic               sel_pin_i,
  input  logic               sel_reg_i,
  input  logic [1:0]         alarm_i,
  input  logic [TIMER_W-1:0] valid_time_i,
  input  logic               act_oe_i,
  output logic               active_sel_o,
  output logic               act_ind_o,
  output logic               hold_o,
  output logic               switch_o
);
  logic first, second, revert_ok, man_sel, sel;

  rcs_prio_decode u_prio (
    .prio_first_i (prio_first_i),
    .prio_second_i(prio_second_i),
    .first_o      (first),
    .second_o     (second)
  );

  rcs_valid_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(alarm_i[first] || !auto_en_i),
    .limit_i(valid_time_i),
    .done_o (revert_ok)
  );

  assign man_sel = sel_pin_en_i ? sel_pin_i : sel_reg_i;

  rcs_sel_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_en_i  (auto_en_i),
    .revert_en_i(revert_en_i),
    .man_sel_i  (man_sel),
    .first_i    (first),
    .second_i   (second),
    .alarm_i    (alarm_i),
    .revert_ok_i(revert_ok),
    .sel_o      (sel),
    .hold_o     (hold_o),
    .switch_o   (switch_o)
  );

  assign active_sel_o = sel;
  assign act_ind_o    = act_oe_i ? sel : 1'bz;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       auto_en_i,
  input logic       sel_pin_en_i,
  input logic       sel_pin_i,
  input logic       sel_reg_i,
  input logic [1:0] alarm_i,
  input logic       act_oe_i,
  input logic       active_sel_o,
  input logic       act_ind_o,
  input logic       hold_o,
  input logic       switch_o
);
  p_manual_pin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i && sel_pin_en_i) |=> (active_sel_o == $past(sel_pin_i)));
  p_manual_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i && !sel_pin_en_i) |=> (active_sel_o == $past(sel_reg_i)));
  p_manual_no_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> !hold_o);
  p_failover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !hold_o && alarm_i[active_sel_o] && !alarm_i[~active_sel_o])
      |=> (active_sel_o != $past(active_sel_o)));
  p_hold_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !hold_o && alarm_i == 2'b11) |=> hold_o);
  p_hold_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> $stable(active_sel_o));
  p_change_pulses_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_sel_o != $past(active_sel_o)) |-> switch_o);
  p_pulse_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> ((active_sel_o != $past(active_sel_o)) || $fell(hold_o)));
  p_indicator_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_oe_i |-> (act_ind_o === active_sel_o));
endmodule

bind ref_clk_selector rcs_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .auto_en_i   (auto_en_i),
  .sel_pin_en_i(sel_pin_en_i),
  .sel_pin_i   (sel_pin_i),
  .sel_reg_i   (sel_reg_i),
  .alarm_i     (alarm_i),
  .act_oe_i    (act_oe_i),
  .active_sel_o(active_sel_o),
  .act_ind_o   (act_ind_o),
  .hold_o      (hold_o),
  .switch_o    (switch_o)
);

// File: tb/sim_ref_clk_selector.sv
`timescale 1ns/1ps
module sim_ref_clk_selector;
  localparam int TW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          auto_en_i = 1'b0, revert_en_i = 1'b0;
  logic [1:0]    prio_first_i = 2'b00, prio_second_i = 2'b01;
  logic          sel_pin_en_i = 1'b0, sel_pin_i = 1'b0, sel_reg_i = 1'b0;
  logic [1:0]    alarm_i = 2'b00;
  logic [TW-1:0] valid_time_i = '0;
  logic          act_oe_i = 1'b1;
  logic          active_sel_o, act_ind_o, hold_o, switch_o;

  int n_chk = 0, n_fail = 0;
  logic m_sel = 1'b0, m_hold = 1'b0, m_sw = 1'b0;
  int   m_cnt = 0;

  always #5 clk_i = ~clk_i;

  ref_clk_selector #(.TIMER_W(TW)) u0 (.*);

  // R3 priority decode
  function automatic logic first_of(input logic [1:0] a, input logic [1:0] b);
    if (a[1] || b[1] || a == b) return 1'b0;
    return a[0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    logic f, nsel, nhold, nsw;
    logic done;
    f = first_of(prio_first_i, prio_second_i);
    done = !(alarm_i[f] || !auto_en_i) && (m_cnt >= int'(valid_time_i));
    nsel = m_sel; nhold = m_hold; nsw = 1'b0;
    if (!auto_en_i) begin
      nhold = 1'b0;
      nsel = sel_pin_en_i ? sel_pin_i : sel_reg_i;
      nsw = (nsel != m_sel);
    end else if (!m_hold) begin
      if (alarm_i[m_sel]) begin
        if (!alarm_i[~m_sel]) begin nsel = ~m_sel; nsw = 1'b1; end
        else nhold = 1'b1;
      end else if (revert_en_i && m_sel != f && done) begin
        nsel = f; nsw = 1'b1;
      end
    end else if (alarm_i != 2'b11) begin
      nhold = 1'b0; nsw = 1'b1;
      nsel = alarm_i[f] ? ~f : f;
    end
    if (alarm_i[f] || !auto_en_i) m_cnt = 0;
    else if (m_cnt < 65535) m_cnt++;
    m_sel = nsel; m_hold = nhold; m_sw = nsw;
  endtask

  task automatic step(input string tag);
    model_update();
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, "sel", active_sel_o, m_sel);
    chk(tag, "hold", hold_o, m_hold);
    chk("R9", "switch", switch_o, m_sw);
    n_chk++;
    if (act_ind_o !== (act_oe_i ? m_sel : 1'bz)) begin
      n_fail++;
      $display("FAIL R10 ind: actual %b expected %b", act_ind_o, act_oe_i ? m_sel : 1'bz);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1", "sel", active_sel_o, 1'b0);
    chk("R1", "hold", hold_o, 1'b0);
    chk("R1", "switch", switch_o, 1'b0);

    // R2 manual: pin then register
    sel_pin_en_i = 1; sel_pin_i = 1; sel_reg_i = 0; step("R2");
    chk("R2", "pin sel", active_sel_o, 1'b1);
    sel_pin_en_i = 0; step("R2");
    chk("R2", "reg sel", active_sel_o, 1'b0);
    sel_reg_i = 1; alarm_i = 2'b11; step("R2");
    chk("R2", "no hold", hold_o, 1'b0);

    // R8 non-revertive: on input 2, first = input 1, stays
    alarm_i = 2'b00; auto_en_i = 1; revert_en_i = 0; valid_time_i = 0;
    repeat (6) step("R8");
    chk("R8", "stay", active_sel_o, 1'b1);

    // R4 failover 2 -> 1, then 1 -> 2
    alarm_i = 2'b10; step("R4");
    chk("R4", "to in1", active_sel_o, 1'b0);
    alarm_i = 2'b01; step("R4");
    chk("R4", "to in2", active_sel_o, 1'b1);

    // R7 revert after T+1 clean edges, T=3
    revert_en_i = 1; valid_time_i = 3; alarm_i = 2'b00;
    repeat (3) step("R7");
    chk("R7", "not yet", active_sel_o, 1'b1);
    step("R7");
    chk("R7", "reverted", active_sel_o, 1'b0);

    // R3 reserved/duplicate/swapped codes
    valid_time_i = 0; prio_first_i = 2'b01; prio_second_i = 2'b00; step("R3");
    chk("R3", "in2 first", active_sel_o, 1'b1);
    prio_first_i = 2'b11; step("R3");
    chk("R3", "reserved", active_sel_o, 1'b0);
    prio_first_i = 2'b01; prio_second_i = 2'b01; step("R3");
    chk("R3", "duplicate", active_sel_o, 1'b0);

    // R5 hold and R6 exit; R10 tri-state
    prio_first_i = 2'b01; prio_second_i = 2'b00; step("R3");
    alarm_i = 2'b11; act_oe_i = 0; step("R5");
    chk("R5", "hold", hold_o, 1'b1);
    repeat (3) step("R5");
    chk("R5", "kept", active_sel_o, 1'b1);
    alarm_i = 2'b10; step("R6");
    chk("R6", "exit", hold_o, 1'b0);
    chk("R6", "second", active_sel_o, 1'b0);
    chk("R6", "pulse", switch_o, 1'b1);
    act_oe_i = 1;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) alarm_i[0] = ~alarm_i[0];
      if ($urandom_range(15) == 0) alarm_i[1] = ~alarm_i[1];
      if ($urandom_range(63) == 0) begin
        prio_first_i = 2'($urandom_range(3)); prio_second_i = 2'($urandom_range(3));
      end
      if ($urandom_range(127) == 0) auto_en_i = ~auto_en_i;
      if ($urandom_range(63) == 0) revert_en_i = ~revert_en_i;
      if ($urandom_range(31) == 0) valid_time_i = TW'($urandom_range(6));
      sel_pin_en_i = 1'($urandom_range(1)); sel_pin_i = 1'($urandom_range(1));
      if ($urandom_range(7) == 0) sel_reg_i = ~sel_reg_i;
      act_oe_i = ($urandom_range(7) != 0);
      step(auto_en_i ? "R4/R5/R6/R7" : "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule